// File: doc/BRIEF.md
# Translation Lookaside Buffer with Page-Table Walk

This block caches virtual-to-physical page translations for a single requester. A request carries a virtual address and a read/write flag. The block compares the virtual page number with every cached translation at once. On a hit, it returns the physical address one cycle later. That address is the cached physical page number followed by the untouched page offset. Each cached translation keeps a referenced flag and a modified flag, and the block updates both as accesses land.

When no cached translation matches, the block stalls the requester. It then fetches one page-table entry from memory, at the page-table base plus the virtual page number. If the entry is marked present, the block installs it and replays the request, and the replay hits. If the entry is not present, the block reports a page fault instead and installs nothing. Refill uses a free slot when one exists. Once the cache is full, a pseudo-random generator picks the slot to overwrite. A flush input drops every translation in one cycle.

Top module: `walkTlb`

## Requirements
- R1: An accepted request whose virtual page matches a valid entry makes `rspValid` high for exactly the next cycle, with `rspPaddr` = {cached physical page, request offset}, and raises no memory request.
- R2: `rspRefPrev` reports the entry's reference bit as it was before the access: 0 on the first access after the entry was installed (including the replay after refill), 1 on later accesses.
- R3: A write access sets the entry's dirty bit, and a read leaves it unchanged. `rspDirty` reports the dirty bit after the access, and the replay of a write miss also sets it.
- R4: On a miss, `memReqValid` rises in the cycle after acceptance with `memAddr` = `ptBase` + virtual page number. It stays high until `memRspValid`, and `reqReady` stays low for the whole walk.
- R5: A fetched entry is present when bit PPN_W of `memRspData` is 1, and its physical page sits in bits PPN_W-1:0. A present entry is installed and the request is replayed. `rspValid` follows two cycles after the `memRspValid` cycle.
- R6: A fetched entry with bit PPN_W clear makes `pageFault` high for exactly one cycle, in the cycle after `memRspValid`, with `faultVpn` holding the page. No `rspValid` is produced and nothing is installed, so a repeat access walks again.
- R7: While an invalid slot exists, a refill never overwrites a valid entry, so ENTRIES distinct pages filled one after another all hit afterwards.
- R8: When all slots are valid, a refill overwrites one entry chosen by a free-running LFSR, and the new page hits afterwards.
- R9: `flush` held high for one cycle invalidates every entry, so the next access to any page walks.
- R10: After reset, `reqReady` is 1, `rspValid`, `pageFault` and `memReqValid` are 0, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| ptBase | input | MEM_AW | Page-table base address |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | VPN_W+OFF_W | Virtual address of the request |
| reqWrite | input | 1 | 1 for a write access |
| rspValid | output | 1 | Translation result valid (one cycle) |
| rspPaddr | output | PPN_W+OFF_W | Physical address |
| rspRefPrev | output | 1 | Reference bit before this access |
| rspDirty | output | 1 | Dirty bit after this access |
| pageFault | output | 1 | Page-fault pulse |
| faultVpn | output | VPN_W | Faulting virtual page number |
| memReqValid | output | 1 | Page-table read request |
| memAddr | output | MEM_AW | Page-table entry address |
| memRspValid | input | 1 | Page-table read data valid |
| memRspData | input | PPN_W+1 | Page-table entry: present bit on top, physical page below |

## Verification
A hit is due one cycle after the accepting edge. With the bench's one-cycle memory, a refill result is due four cycles after acceptance and a fault three cycles after. Each access task counts cycles from the accepting edge, sampling on the falling edge. It compares that count with these figures, so a result that is early or late fails even when the address is right. The task also watches for `memReqValid` while it waits and records `memAddr`. That separates true hits from walks, confirms the stall, and lets the replacement tests count which pages were evicted by seeing which ones walk again.

// File: rtl/walkTlbPkg.sv
package walkTlbPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_RETRY = 2'd2
  } tlbState_t;

  typedef struct packed {
    logic useHeld;   // look up the captured request instead of the port
    logic capture;   // latch the incoming request
    logic touch;     // update reference/dirty of the hit entry
    logic refill;    // install the fetched translation
    logic respond;   // emit a translation result
    logic fault;     // emit a page-fault pulse
  } tlbStrobes_t;

endpackage

// File: rtl/walkTlbLfsr.sv
module walkTlbLfsr #(
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
  parameter int OUT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [OUT_W-1:0] pick
);

  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= LFSR_W'(1);
    else       state <= (state >> 1) ^ (state[0] ? TAPS : '0);
  end

  assign pick = state[OUT_W-1:0];

  assert_lfsr_alive_R8: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

endmodule

// File: rtl/walkTlbDatapath.sv
module walkTlbDatapath
  import walkTlbPkg::*;
#(
  parameter int VPN_W   = 8,
  parameter int PPN_W   = 8,
  parameter int OFF_W   = 4,
  parameter int ENTRIES = 4,
  parameter int MEM_AW  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic [VPN_W+OFF_W-1:0] reqVaddr,
  input  logic                   reqWrite,
  input  logic [MEM_AW-1:0]      ptBase,
  input  logic [PPN_W:0]         memRspData,
  input  tlbStrobes_t            strobes,
  output logic [MEM_AW-1:0]      memAddr,
  output logic                   hit,
  output logic                   pteValid,
  output logic                   rspValid,
  output logic [PPN_W+OFF_W-1:0] rspPaddr,
  output logic                   rspRefPrev,
  output logic                   rspDirty,
  output logic                   pageFault,
  output logic [VPN_W-1:0]       faultVpn
);

  localparam int VA_W  = VPN_W + OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] entValid, entRef, entDirty;
  logic [VPN_W-1:0]   entVpn [ENTRIES];
  logic [PPN_W-1:0]   entPpn [ENTRIES];

  logic [VA_W-1:0]  heldVaddr;
  logic             heldWrite;
  logic [VPN_W-1:0] heldVpn, lookVpn;
  logic [OFF_W-1:0] lookOff;
  logic             lookWrite;

  logic [ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0]   hitIdx, freeIdx, randIdx, victimIdx;
  logic               anyFree;

  assign heldVpn   = heldVaddr[VA_W-1:OFF_W];
  assign lookVpn   = strobes.useHeld ? heldVpn : reqVaddr[VA_W-1:OFF_W];
  assign lookOff   = strobes.useHeld ? heldVaddr[OFF_W-1:0] : reqVaddr[OFF_W-1:0];
  assign lookWrite = strobes.useHeld ? heldWrite : reqWrite;

  assign memAddr  = ptBase + MEM_AW'(heldVpn);
  assign pteValid = memRspData[PPN_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldVaddr <= '0;
      heldWrite <= 1'b0;
    end else if (strobes.capture) begin
      heldVaddr <= reqVaddr;
      heldWrite <= reqWrite;
    end
  end

  // Parallel compare against every slot.
  for (genvar g = 0; g < ENTRIES; g++) begin : gCompare
    assign hitVec[g] = entValid[g] && (entVpn[g] == lookVpn);
  end

  assign hit = |hitVec;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hitVec[i]) hitIdx = IDX_W'(i);
  end

  // Lowest free slot wins; otherwise the LFSR picks.
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  walkTlbLfsr #(.LFSR_W(8), .TAPS(8'hB8), .OUT_W(IDX_W)) uLfsr (
    .clk (clk),
    .rstN(rstN),
    .pick(randIdx)
  );

  assign victimIdx = anyFree ? freeIdx : randIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      entRef   <= '0;
      entDirty <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entVpn[i] <= '0;
        entPpn[i] <= '0;
      end
    end else if (flush) begin
      entValid <= '0;
      entRef   <= '0;
      entDirty <= '0;
    end else begin
      if (strobes.refill) begin
        entValid[victimIdx] <= 1'b1;
        entVpn[victimIdx]   <= heldVpn;
        entPpn[victimIdx]   <= memRspData[PPN_W-1:0];
        entRef[victimIdx]   <= 1'b0;
        entDirty[victimIdx] <= 1'b0;
      end
      if (strobes.touch) begin
        entRef[hitIdx] <= 1'b1;
        if (lookWrite) entDirty[hitIdx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspPaddr   <= '0;
      rspRefPrev <= 1'b0;
      rspDirty   <= 1'b0;
      pageFault  <= 1'b0;
      faultVpn   <= '0;
    end else begin
      rspValid  <= strobes.respond;
      pageFault <= strobes.fault;
      if (strobes.respond) begin
        rspPaddr   <= {entPpn[hitIdx], lookOff};
        rspRefPrev <= entRef[hitIdx];
        rspDirty   <= entDirty[hitIdx] | lookWrite;
      end
      if (strobes.fault) faultVpn <= heldVpn;
    end
  end

  assert_unique_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  assert_free_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.refill && !(&entValid)) |-> !entValid[victimIdx]);

  assert_retry_hits_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.refill && !flush) |-> hit);

  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    pageFault |=> !pageFault);

  assert_no_rsp_on_fault_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && pageFault));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(flush) |-> (entValid == '0));

endmodule

// File: rtl/walkTlbControl.sv
module walkTlbControl
  import walkTlbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        hit,
  input  logic        memRspValid,
  input  logic        pteValid,
  output logic        reqReady,
  output logic        memReqValid,
  output tlbStrobes_t strobes
);

  tlbState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    strobes.useHeld = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.capture = 1'b1;
          if (hit) begin
            strobes.touch   = 1'b1;
            strobes.respond = 1'b1;
          end else begin
            stateNext = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (memRspValid) begin
          if (pteValid) begin
            strobes.refill = 1'b1;
            stateNext = ST_RETRY;
          end else begin
            strobes.fault = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_RETRY: begin
        if (hit) begin
          strobes.touch   = 1'b1;
          strobes.respond = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stateNext = ST_WALK;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_WALK);

  assert_walk_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> memReqValid);

  assert_walk_follows_miss_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> $past(reqValid && !hit) || $past(!reqReady && !hit));

  assert_single_action_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.touch && strobes.refill) && !(strobes.respond && strobes.fault));

endmodule

// File: rtl/walkTlb.sv
module walkTlb
  import walkTlbPkg::*;
#(
  parameter int VPN_W   = 8,
  parameter int PPN_W   = 8,
  parameter int OFF_W   = 4,
  parameter int ENTRIES = 4,
  parameter int MEM_AW  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic [MEM_AW-1:0]      ptBase,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [VPN_W+OFF_W-1:0] reqVaddr,
  input  logic                   reqWrite,
  output logic                   rspValid,
  output logic [PPN_W+OFF_W-1:0] rspPaddr,
  output logic                   rspRefPrev,
  output logic                   rspDirty,
  output logic                   pageFault,
  output logic [VPN_W-1:0]       faultVpn,
  output logic                   memReqValid,
  output logic [MEM_AW-1:0]      memAddr,
  input  logic                   memRspValid,
  input  logic [PPN_W:0]         memRspData
);

  tlbStrobes_t strobes;
  logic hit, pteValid;

  walkTlbControl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .hit        (hit),
    .memRspValid(memRspValid),
    .pteValid   (pteValid),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .strobes    (strobes)
  );

  walkTlbDatapath #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
    .ENTRIES(ENTRIES), .MEM_AW(MEM_AW)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .ptBase     (ptBase),
    .memRspData (memRspData),
    .strobes    (strobes),
    .memAddr    (memAddr),
    .hit        (hit),
    .pteValid   (pteValid),
    .rspValid   (rspValid),
    .rspPaddr   (rspPaddr),
    .rspRefPrev (rspRefPrev),
    .rspDirty   (rspDirty),
    .pageFault  (pageFault),
    .faultVpn   (faultVpn)
  );

  assert_stall_during_walk_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

endmodule

// File: tb/walkTlb_test.sv
`timescale 1ns/1ps
module walkTlb_test;

  localparam logic [15:0] PT_BASE = 16'h2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        reqValid = 1'b0;
  logic [11:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqReady, rspValid, rspRefPrev, rspDirty, pageFault, memReqValid;
  logic [11:0] rspPaddr;
  logic [7:0]  faultVpn;
  logic [15:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [8:0]  memRspData = '0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  walkTlb uut (
    .clk(clk), .rstN(rstN), .flush(flush), .ptBase(PT_BASE),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspRefPrev(rspRefPrev), .rspDirty(rspDirty),
    .pageFault(pageFault), .faultVpn(faultVpn),
    .memReqValid(memReqValid), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // Page table model: pages 0xF0..0xFF are absent, others map to vpn ^ 0x5A.
  function automatic logic [8:0] pteFor(input logic [7:0] vpn);
    return {(vpn[7:4] != 4'hF), vpn ^ 8'h5A};
  endfunction

  function automatic logic [11:0] expPa(input logic [11:0] va);
    return {va[11:4] ^ 8'h5A, va[3:0]};
  endfunction

  // One-cycle-latency memory responder.
  always @(posedge clk) begin
    if (!rstN) begin
      memRspValid <= 1'b0;
    end else begin
      memRspValid <= memReqValid && !memRspValid;
      memRspData  <= pteFor(8'(memAddr - PT_BASE));
    end
  end

  // Results of the last access.
  bit          gotRsp, gotFault, walked, stallOk;
  int          cycles;
  logic [11:0] gotPa;
  logic        gotRef, gotDirty;
  logic [7:0]  gotFVpn;
  logic [15:0] gotMemAddr;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] va, input logic wr);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    cycles = 1; gotRsp = 0; gotFault = 0; walked = 0; stallOk = 1;
    for (int k = 0; k < 40; k++) begin
      if (rspValid) begin
        gotRsp = 1; gotPa = rspPaddr; gotRef = rspRefPrev; gotDirty = rspDirty;
        break;
      end
      if (pageFault) begin
        gotFault = 1; gotFVpn = faultVpn;
        break;
      end
      if (memReqValid) begin
        walked = 1; gotMemAddr = memAddr;
        if (reqReady) stallOk = 0;
      end
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic tReset;
    check(reqReady == 1'b1, "R10 reqReady", 32'(reqReady), 1);
    check(!rspValid && !pageFault && !memReqValid, "R10 outputs idle",
          {29'd0, rspValid, pageFault, memReqValid}, 0);
  endtask

  task automatic tMissRefill;
    access(12'h123, 1'b0);
    check(walked, "R4 miss walks", 32'(walked), 1);
    check(gotMemAddr == PT_BASE + 16'h12, "R4 memAddr", 32'(gotMemAddr), 32'(PT_BASE + 16'h12));
    check(stallOk, "R4 stall during walk", 32'(stallOk), 1);
    check(gotRsp && cycles == 4, "R5 refill latency", 32'(cycles), 4);
    check(gotPa == expPa(12'h123), "R5 refill paddr", 32'(gotPa), 32'(expPa(12'h123)));
    check(gotRef == 1'b0, "R2 fresh ref", 32'(gotRef), 0);
  endtask

  task automatic tHit;
    access(12'h12A, 1'b0);
    check(!walked && gotRsp && cycles == 1, "R1 hit latency", 32'(cycles), 1);
    check(gotPa == expPa(12'h12A), "R1 hit paddr", 32'(gotPa), 32'(expPa(12'h12A)));
    check(gotRef == 1'b1, "R2 ref after use", 32'(gotRef), 1);
    check(gotDirty == 1'b0, "R3 read leaves clean", 32'(gotDirty), 0);
  endtask

  task automatic tDirty;
    access(12'h127, 1'b1);
    check(gotRsp && gotDirty, "R3 write sets dirty", 32'(gotDirty), 1);
    access(12'h120, 1'b0);
    check(gotRsp && gotDirty, "R3 dirty persists", 32'(gotDirty), 1);
    access(12'h345, 1'b1);
    check(walked && gotRsp && gotDirty, "R3 write miss dirty", 32'(gotDirty), 1);
    access(12'h346, 1'b0);
    check(!walked && gotDirty && gotPa == expPa(12'h346), "R3 write miss persists",
          32'(gotPa), 32'(expPa(12'h346)));
  endtask

  task automatic tFault;
    access(12'hF21, 1'b0);
    check(gotFault && !gotRsp && cycles == 3, "R6 fault latency", 32'(cycles), 3);
    check(gotFVpn == 8'hF2, "R6 faultVpn", 32'(gotFVpn), 32'h0F2);
    @(negedge clk);
    check(!pageFault && !rspValid, "R6 single pulse", 32'(pageFault), 0);
    access(12'hF21, 1'b0);
    check(walked && gotFault, "R6 not installed", 32'(walked), 1);
  endtask

  task automatic tFlush;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    access(12'h123, 1'b0);
    check(walked, "R9 flush invalidates", 32'(walked), 1);
    check(gotRef == 1'b0, "R9 fresh after flush", 32'(gotRef), 0);
  endtask

  task automatic tFillFree;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int p = 1; p <= 4; p++) access({4'(p), 8'h00}, 1'b0);
    for (int p = 1; p <= 4; p++) begin
      access({4'(p), 8'h03}, 1'b0);
      check(!walked && gotRsp && gotPa == expPa({4'(p), 8'h03}), "R7 free slots kept",
            32'(walked), 0);
    end
  endtask

  task automatic tRandomVictim;
    int misses = 0;
    access(12'h500, 1'b0);
    check(walked && gotRsp, "R8 full refill", 32'(walked), 1);
    access(12'h505, 1'b0);
    check(!walked && gotPa == expPa(12'h505), "R8 new page hits", 32'(walked), 0);
    for (int p = 1; p <= 4; p++) begin
      access({4'(p), 8'h09}, 1'b0);
      if (walked) misses++;
      check(gotRsp && gotPa == expPa({4'(p), 8'h09}), "R8 paddr after eviction",
            32'(gotPa), 32'(expPa({4'(p), 8'h09})));
    end
    check(misses >= 1, "R8 one entry evicted", 32'(misses), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMissRefill();
    tHit();
    tDirty();
    tFault();
    tFlush();
    tFillFree();
    tRandomVictim();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule